// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the serial-side command engine of a byte-wide nonvolatile memory. A host drives it as a mode-0 SPI master over an active-low select, a serial clock and a data line. The engine turns the incoming bit stream into requests for the surrounding logic. It decodes a one-byte command and gathers a two-byte address. It then streams array or status bytes back on a tri-stateable output, or it hands each received data byte, tagged with its page-local address, to a separate programming sequencer. The array itself, the write-enable latch and the status/protection logic live outside. They reach this block through a combinational read port, a status byte input, a busy flag and single-cycle strobes.

All serial pins are sampled by a system clock that runs well above the serial clock rate. A rising serial-clock edge shifts in one bit. A falling edge advances the output bit. An active-low pause input freezes the transfer at its current bit position, so the host can interleave other traffic without restarting the command.

Top module: `spi_mem_cmd`

## Requirements
- R1: While `cs_n` is high, `so_oe` is 0, serial input is not taken, and any partial command is discarded; the next frame decodes its first byte as a command.
- R2: Bytes are shifted MSB first. Command byte 0000_b110 pulses `wel_set` once and 0000_b100 pulses `wel_clr` once, where bit 3 (b) may be either value.
- R3: A command byte whose upper nibble is nonzero, or whose low three bits are 000 or 111, produces no strobe and leaves `so_oe` at 0 until the frame ends, whatever follows.
- R4: Command 0000_b011 takes a 16-bit address MSB first and uses only its low log2(DEPTH) bits. The addressed byte then appears on `so` MSB first: its first bit is valid from the falling SCK edge after the last address bit, and `so_oe` is 1 for every data bit.
- R5: During a read, the address steps by one per byte and wraps from DEPTH-1 to 0.
- R6: Command 0000_b101 returns `stat_rdata` on `so`, repeated for every further byte of the frame.
- R7: Command 0000_b010 takes a 16-bit address, then emits one `wr_valid` per complete data byte with that byte on `wr_data`. The low log2(PAGE) bits of `wr_addr` count up from the given address and wrap inside the page, while the upper bits stay fixed. A partial byte at the end of the frame is dropped.
- R8: Command 0000_b001 pulses `stat_wr` once, with the first data byte on `stat_data`; later bytes in that frame are ignored.
- R9: When `busy` is 1 at the end of a command byte, every command except read-status is ignored for the rest of the frame: no strobe, and `so_oe` stays 0.
- R10: Pulling `hold_n` low while SCK is low pauses the transfer. SCK edges are then ignored and `so_oe` is 0. Raising `hold_n` while SCK is low resumes at the same bit.
- R11: `wel_set`, `wel_clr`, `stat_wr` and `wr_valid` are single-cycle pulses, and no two are high together.
- R12: While the output is enabled, `so` changes only in the system cycle that follows a falling SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; a frame spans one low period |
| sck | input | 1 | Serial clock (mode 0) |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| busy | input | 1 | Internal programming cycle in progress |
| stat_rdata | input | 8 | Status byte to return |
| mem_addr | output | log2(DEPTH) | Array read address |
| mem_rdata | input | 8 | Array read data, valid in the same cycle as `mem_addr` |
| wel_set | output | 1 | Set the write-enable latch |
| wel_clr | output | 1 | Clear the write-enable latch |
| stat_wr | output | 1 | Status write strobe |
| stat_data | output | 8 | Status byte to store |
| wr_valid | output | 1 | Data byte for the programming sequencer |
| wr_addr | output | log2(DEPTH) | Address of that byte |
| wr_data | output | 8 | The byte |

## Verification
The assertions assume that the SCK, select, data and pause pins are already synchronous to `clk` and that each SCK level lasts at least two system cycles. They also assume that `hold_n` moves only while SCK is low, with SCK held still for a cycle around each change, and that `busy` is steady around command boundaries. The bench keeps every serial level for four system cycles and changes `si`, `hold_n` and `cs_n` only while SCK is low. It toggles `busy` only between frames, and its random frames draw commands, addresses, lengths and data within those limits.

// File: rtl/spi_mem_cmd.sv
module spi_mem_cmd #(
  parameter int DEPTH = 2048,
  parameter int PAGE  = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(PAGE),
  localparam int SW = (AW > 8) ? AW : 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  input  logic          hold_n,
  output logic          so,
  output logic          so_oe,
  input  logic          busy,
  input  logic [7:0]    stat_rdata,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          wel_set,
  output logic          wel_clr,
  output logic          stat_wr,
  output logic [7:0]    stat_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);

  typedef enum logic [2:0] {P_OP, P_ADDR, P_RD, P_WR, P_SW, P_SKIP} phase_t;

  phase_t        phase;
  logic          sck_q, held, out_act, pend, is_st, is_wr, ab, so_q;
  logic [2:0]    bcnt;
  logic [SW-2:0] sr;
  logic [AW-1:0] addr;
  logic [7:0]    tx;

  wire          active = ~cs_n & ~held;
  wire          rise   = active & sck & ~sck_q;
  wire          fall   = active & ~sck & sck_q;
  wire [SW-1:0] sh     = {sr, si};
  wire          last   = rise & (bcnt == 3'd7);
  wire [7:0]    op     = sh[7:0];
  wire          op_ok  = (op[7:4] == 4'd0) && (op[2:0] != 3'b000) && (op[2:0] != 3'b111);

  assign so       = so_q;
  assign so_oe    = ~cs_n & ~held & out_act & (phase == P_RD);
  assign mem_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_OP;  sck_q <= 1'b0; held <= 1'b0; out_act <= 1'b0;
      pend <= 1'b0;   is_st <= 1'b0; is_wr <= 1'b0; ab <= 1'b0; so_q <= 1'b0;
      bcnt <= '0;     sr <= '0;      addr <= '0;   tx <= '0;
      wel_set <= 1'b0; wel_clr <= 1'b0; stat_wr <= 1'b0; stat_data <= '0;
      wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      sck_q    <= sck;
      wel_set  <= 1'b0;
      wel_clr  <= 1'b0;
      stat_wr  <= 1'b0;
      wr_valid <= 1'b0;
      pend     <= 1'b0;
      if (pend) tx <= is_st ? stat_rdata : mem_rdata;
      if (cs_n) begin
        phase <= P_OP; bcnt <= '0; held <= 1'b0; out_act <= 1'b0; ab <= 1'b0;
      end else begin
        if (!sck) held <= ~hold_n;
        if (rise) begin
          sr   <= sh[SW-2:0];
          bcnt <= bcnt + 3'd1;
        end
        if (fall && phase == P_RD) begin
          so_q    <= tx[~bcnt];
          out_act <= 1'b1;
        end
        if (last) begin
          case (phase)
            P_OP: begin
              if (!op_ok || (busy && op[2:0] != 3'b101)) phase <= P_SKIP;
              else begin
                case (op[2:0])
                  3'b110: begin wel_set <= 1'b1; phase <= P_SKIP; end
                  3'b100: begin wel_clr <= 1'b1; phase <= P_SKIP; end
                  3'b101: begin is_st <= 1'b1; pend <= 1'b1; phase <= P_RD; end
                  3'b001: phase <= P_SW;
                  3'b011: begin is_st <= 1'b0; is_wr <= 1'b0; phase <= P_ADDR; end
                  default: begin is_st <= 1'b0; is_wr <= 1'b1; phase <= P_ADDR; end
                endcase
              end
            end
            P_ADDR: begin
              ab <= ~ab;
              if (ab) begin
                addr <= sh[AW-1:0];
                if (is_wr) phase <= P_WR;
                else begin
                  pend  <= 1'b1;
                  phase <= P_RD;
                end
              end
            end
            P_RD: begin
              if (!is_st) addr <= addr + 1'b1;
              pend <= 1'b1;
            end
            P_WR: begin
              wr_valid       <= 1'b1;
              wr_data        <= sh[7:0];
              wr_addr        <= addr;
              addr[PW-1:0]   <= addr[PW-1:0] + 1'b1;
            end
            P_SW: begin
              stat_wr   <= 1'b1;
              stat_data <= sh[7:0];
              phase     <= P_SKIP;
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/spi_mem_cmd_chk.sv
module spi_mem_cmd_chk #(
  parameter int DEPTH = 2048,
  parameter int PAGE  = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(PAGE)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sck,
  input logic          hold_n,
  input logic          so,
  input logic          so_oe,
  input logic          busy,
  input logic          wel_set,
  input logic          wel_clr,
  input logic          stat_wr,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr
);

  logic          seen;
  logic [AW-1:0] last_wa;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; last_wa <= '0;
    end else if (cs_n) begin
      seen <= 1'b0;
    end else if (wr_valid) begin
      seen <= 1'b1; last_wa <= wr_addr;
    end
  end

  p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wel_set, wel_clr, stat_wr, wr_valid}));

  p_pulse_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  p_busy_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wel_set |-> !$past(busy));

  p_busy_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |-> !$past(busy));

  p_page_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && seen) |-> ((wr_addr[PW-1:0] == last_wa[PW-1:0] + 1'b1) &&
                            (wr_addr[AW-1:PW] == last_wa[AW-1:PW])));

  p_so_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && so != $past(so)) |-> (!$past(sck) && $past(sck, 2)));

  p_oe_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> (!cs_n && hold_n));

endmodule

bind spi_mem_cmd spi_mem_cmd_chk #(.DEPTH(DEPTH), .PAGE(PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
  .so(so), .so_oe(so_oe), .busy(busy), .wel_set(wel_set), .wel_clr(wel_clr),
  .stat_wr(stat_wr), .wr_valid(wr_valid), .wr_addr(wr_addr)
);

// File: tb/tb_spi_mem_cmd.sv
module tb_spi_mem_cmd;
  localparam int DEPTH = 2048;
  localparam int PAGE  = 32;
  localparam int AW = 11;
  localparam int HP = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
  logic [7:0] stat_rdata = 8'h5A;
  logic so, so_oe, wel_set, wel_clr, stat_wr, wr_valid;
  logic [7:0] stat_data, wr_data, mem_rdata;
  logic [AW-1:0] mem_addr, wr_addr;

  int checks = 0, errors = 0;
  int nw = 0, nset = 0, nclr = 0, nsw = 0;
  logic [AW-1:0] wa [0:255];
  logic [7:0]    wd [0:255];
  logic [7:0]    swd;

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {a[AW-1:8], 5'h15};
  endfunction

  function automatic bit op_valid(input logic [7:0] o);
    return (o[7:4] == 4'd0) && (o[2:0] != 3'b000) && (o[2:0] != 3'b111);
  endfunction

  assign mem_rdata = pat(mem_addr);

  spi_mem_cmd #(.DEPTH(DEPTH), .PAGE(PAGE)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .busy(busy), .stat_rdata(stat_rdata),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .wel_set(wel_set), .wel_clr(wel_clr),
    .stat_wr(stat_wr), .stat_data(stat_data), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (wr_valid) begin wa[nw % 256] = wr_addr; wd[nw % 256] = wr_data; nw++; end
    if (wel_set) nset++;
    if (wel_clr) nclr++;
    if (stat_wr) begin nsw++; swd = stat_data; end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic d, output logic q, output logic oe);
    si = d; tick(HP);
    sck = 1'b1; q = so; oe = so_oe;
    tick(HP); sck = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] d, output logic [7:0] q, output int oen);
    logic b, e;
    oen = 0;
    for (int i = 7; i >= 0; i--) begin
      sbit(d[i], b, e);
      q[i] = b;
      if (e) oen++;
    end
  endtask

  task automatic start(); cs_n = 1'b0; tick(HP); endtask
  task automatic stop();  tick(HP); cs_n = 1'b1; tick(3 * HP); endtask

  task automatic hold_pause();
    hold_n = 1'b0; tick(2);
    for (int k = 0; k < 3; k++) begin
      si = 1'($urandom); tick(HP);
      sck = 1'b1; tick(1);
      chk(so_oe == 1'b0, "R10 oe during pause", so_oe, 0);
      tick(HP); sck = 1'b0;
    end
    tick(2); hold_n = 1'b1; tick(2);
  endtask

  function automatic logic [7:0] b3(input logic [7:0] o);
    return o | ($urandom % 2 ? 8'h08 : 8'h00);
  endfunction

  task automatic do_read(input logic [15:0] a, input int n);
    logic [7:0] q; int oe, oh;
    logic [AW-1:0] ea;
    start();
    sbyte(b3(8'h03), q, oh);
    sbyte(a[15:8], q, oe); oh += oe;
    sbyte(a[7:0], q, oe);  oh += oe;
    chk(oh == 0, "R4 no output during header", oh, 0);
    for (int k = 0; k < n; k++) begin
      ea = a[AW-1:0] + AW'(k);
      sbyte(8'($urandom), q, oe);
      chk(q == pat(ea), "R4 R5 read byte", q, pat(ea));
      chk(oe == 8, "R4 oe per bit", oe, 8);
    end
    stop();
  endtask

  task automatic do_write(input logic [15:0] a, input int n);
    logic [7:0] q; int oe, n0;
    logic [7:0] d [0:63];
    logic [AW-1:0] ea;
    n0 = nw;
    start();
    sbyte(b3(8'h02), q, oe);
    sbyte(a[15:8], q, oe);
    sbyte(a[7:0], q, oe);
    for (int k = 0; k < n; k++) begin d[k] = 8'($urandom); sbyte(d[k], q, oe); end
    stop();
    chk(nw - n0 == n, "R7 byte count", nw - n0, n);
    for (int k = 0; k < n && k < 64; k++) begin
      ea = {a[AW-1:5], 5'(a[4:0] + 5'(k))};
      chk(wa[(n0 + k) % 256] == ea, "R7 write address", wa[(n0 + k) % 256], ea);
      chk(wd[(n0 + k) % 256] == d[k], "R7 write data", wd[(n0 + k) % 256], d[k]);
    end
  endtask

  task automatic do_bad(input logic [7:0] o);
    logic [7:0] q; int oe, ot, s0, c0, w0, t0;
    s0 = nset; c0 = nclr; w0 = nw; t0 = nsw; ot = 0;
    start();
    sbyte(o, q, oe);
    for (int k = 0; k < 3; k++) begin sbyte(8'($urandom), q, oe); ot += oe; end
    stop();
    chk(ot == 0, "R3 no output after bad command", ot, 0);
    chk((nset - s0) + (nclr - c0) + (nw - w0) + (nsw - t0) == 0, "R3 no strobes",
        (nset - s0) + (nclr - c0) + (nw - w0) + (nsw - t0), 0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] q, o; int oe, ot, n0;
    logic b, e;
    void'($urandom(32'd1234));
    tick(5); rst_n = 1'b1; tick(3);
    chk(so_oe == 1'b0, "R1 reset oe", so_oe, 0);
    chk(nset + nclr + nw + nsw == 0, "R11 no strobe after reset", nset + nclr + nw + nsw, 0);

    start(); sbyte(8'h06, q, oe); stop();
    chk(nset == 1, "R2 set enable", nset, 1);
    start(); sbyte(8'h0C, q, oe); stop();
    chk(nclr == 1, "R2 clear enable, bit3 set", nclr, 1);

    start(); for (int i = 0; i < 4; i++) sbit(1'b0, b, e); stop();
    chk(so_oe == 1'b0, "R1 oe after abort", so_oe, 0);
    start(); sbyte(8'h0E, q, oe); stop();
    chk(nset == 2, "R1 fresh decode after abort", nset, 2);

    do_read(16'h0123, 2);
    do_read(16'hFFFE, 4);

    start(); sbyte(8'h05, q, oe);
    for (int k = 0; k < 2; k++) begin
      sbyte(8'h00, q, oe);
      chk(q == 8'h5A, "R6 status byte", q, 8'h5A);
    end
    stop();

    n0 = nsw;
    start(); sbyte(8'h01, q, oe); sbyte(8'h8C, q, oe); sbyte(8'h33, q, oe); stop();
    chk(nsw - n0 == 1, "R8 one status write", nsw - n0, 1);
    chk(swd == 8'h8C, "R8 status data", swd, 8'h8C);

    do_write(16'h041C, 7);
    n0 = nw;
    start(); sbyte(8'h02, q, oe); sbyte(8'h00, q, oe); sbyte(8'h40, q, oe);
    sbyte(8'hA5, q, oe); for (int i = 0; i < 4; i++) sbit(1'b1, b, e); stop();
    chk(nw - n0 == 1, "R7 partial byte dropped", nw - n0, 1);

    do_bad(8'h07);
    do_bad(8'h08);
    do_bad(8'h43);

    busy = 1'b1; stat_rdata = 8'hFF;
    n0 = nset;
    start(); sbyte(8'h06, q, oe); stop();
    chk(nset == n0, "R9 enable ignored while busy", nset, n0);
    n0 = nw; ot = 0;
    start(); sbyte(8'h02, q, oe); for (int k = 0; k < 3; k++) begin sbyte(8'h11, q, oe); ot += oe; end stop();
    chk(nw == n0, "R9 write ignored while busy", nw, n0);
    start(); sbyte(8'h03, q, oe); for (int k = 0; k < 3; k++) begin sbyte(8'h00, q, oe); ot += oe; end stop();
    chk(ot == 0, "R9 read silent while busy", ot, 0);
    start(); sbyte(8'h0D, q, oe); sbyte(8'h00, q, oe); stop();
    chk(q == 8'hFF, "R9 status readable while busy", q, 8'hFF);
    busy = 1'b0; stat_rdata = 8'h5A; tick(2);

    start(); sbyte(8'h03, q, oe); sbyte(8'h02, q, oe); sbyte(8'h10, q, oe);
    o = 8'h00;
    for (int i = 7; i >= 5; i--) begin sbit(1'b0, b, e); o[i] = b; end
    hold_pause();
    for (int i = 4; i >= 0; i--) begin sbit(1'b0, b, e); o[i] = b; end
    chk(o == pat(11'h210), "R10 read resumes at same bit", o, pat(11'h210));
    sbyte(8'h00, q, oe);
    chk(q == pat(11'h211), "R10 next byte after pause", q, pat(11'h211));
    stop();

    n0 = nw;
    start(); sbyte(8'h02, q, oe); sbyte(8'h00, q, oe); sbyte(8'h80, q, oe);
    for (int i = 7; i >= 4; i--) sbit(1'b1, b, e);
    hold_pause();
    for (int i = 3; i >= 0; i--) sbit(1'b0, b, e);
    stop();
    chk(nw - n0 == 1 && wd[n0 % 256] == 8'hF0, "R10 write data intact after pause", wd[n0 % 256], 8'hF0);

    for (int it = 0; it < 24; it++) begin
      case ($urandom % 4)
        0: do_read(16'($urandom), 1 + int'($urandom % 5));
        1: do_write(16'($urandom), 1 + int'($urandom % 40));
        2: begin
          o = 8'($urandom);
          if (op_valid(o)) o[7] = 1'b1;
          do_bad(o);
        end
        default: begin
          stat_rdata = 8'($urandom);
          start(); sbyte(b3(8'h05), q, oe); sbyte(8'($urandom), q, oe); stop();
          chk(q == stat_rdata, "R6 random status", q, stat_rdata);
        end
      endcase
    end

    summary();
  end
endmodule